// File: doc/BRIEF.md
# Programmable-Timing SPI Master

This block is a single-word SPI master engine. A host hands it one 32-bit word at a time over a valid/ready handshake. The block frames the word with an active-low chip select, clocks it out on MOSI and clocks a word in from MISO at the same time. When the frame is complete it presents the received word with a one-cycle valid strobe. Every interval on the serial side is counted in cycles of the block's own clock. These intervals are the chip-select lead-in before the first clock edge, the tail after the last edge, the minimum release gap between frames, and the high and low halves of each serial clock period. Each interval is set by its own count input.

Clock idle level and sampling edge are selectable, so all four conventional SPI modes are available. Bit order within a byte and byte order within the word are chosen separately for the outgoing and the incoming directions. The block latches all configuration inputs in the cycle it accepts a word. A frame in flight therefore never sees a configuration change.

Top module: `spi_timed_master`

## Requirements
- R1: A word is accepted on a rising clock edge where `tx_valid_i` and `tx_ready_o` are both high. `cs_n_o` is low from the next cycle on. `tx_ready_o` stays low for as long as `cs_n_o` is low.
- R2: The first SCK transition comes exactly `cfg_setup_i`+1 clock cycles after `cs_n_o` falls.
- R3: A frame has exactly 64 SCK transitions. While SCK is high it stays high for `cfg_high_i`+1 cycles, and while low it stays low for `cfg_low_i`+1 cycles. The one exception is the level after the final transition, which R4 governs.
- R4: `cs_n_o` rises exactly `cfg_hold_i`+1 cycles after the final SCK transition.
- R5: After `cs_n_o` rises, it stays high for at least `cfg_idle_i`+1 cycles. `tx_ready_o` goes high in the last of those cycles, so a word that is already waiting is accepted with a gap of exactly `cfg_idle_i`+1 cycles.
- R6: `sck_o` equals `cfg_cpol_i` (1 = idles high) when `cs_n_o` falls and when it rises. In both cases this is the value latched at acceptance.
- R7: With `cfg_cpha_i`=0, MISO is sampled and MOSI must be valid on the first SCK transition of each bit, which moves SCK away from its idle level. MOSI changes on the second transition. With `cfg_cpha_i`=1 the roles of the two transitions are swapped.
- R8: Transmit order is as follows. Serial bit k (k=0 goes first) comes from byte b=k/8 and in-byte position j=k%8. With `cfg_tx_big_i`=0 the source byte is b (bits [7:0] go out first); with 1 it is 3-b. With `cfg_tx_lsb_i`=0 the source bit is 7-j (MSB first); with 1 it is j.
- R9: The received serial bit k is written to the word position given by the R8 mapping, using `cfg_rx_big_i` and `cfg_rx_lsb_i`.
- R10: `rx_valid_o` is high for exactly one cycle, the cycle in which `cs_n_o` rises. `rx_data_o` holds the reordered received word in that cycle.
- R11: Configuration inputs changed after acceptance have no effect on the frame in progress.
- R12: Out of reset, `cs_n_o` is high, `tx_ready_o` is high, `rx_valid_o` is low and `sck_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock; all serial timing is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_setup_i | input | 8 | Chip-select lead-in count |
| cfg_hold_i | input | 8 | Chip-select tail count |
| cfg_idle_i | input | 8 | Minimum release-gap count |
| cfg_low_i | input | 8 | SCK low-phase count |
| cfg_high_i | input | 8 | SCK high-phase count |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_cpha_i | input | 1 | 0: sample on first transition, 1: on second |
| cfg_tx_lsb_i | input | 1 | Transmit bit order, 1 = LSB first |
| cfg_rx_lsb_i | input | 1 | Receive bit order, 1 = LSB first |
| cfg_tx_big_i | input | 1 | Transmit byte order, 1 = most significant byte first |
| cfg_rx_big_i | input | 1 | Receive byte order, 1 = most significant byte first |
| tx_valid_i | input | 1 | Host offers a word |
| tx_data_i | input | 32 | Word to send |
| tx_ready_o | output | 1 | Engine can accept a word |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| rx_data_o | output | 32 | Received word, reordered |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The checker watches every cycle for the following properties. `tx_ready_o` never rises while chip select is active. An accepted word always pulls chip select low on the next edge. The receive strobe is a single-cycle pulse that coincides with chip select releasing. SCK is back at the latched idle level whenever chip select releases. The exact cycle counts of lead-in, clock phases, tail and release gap are measured by the bench's slave model, because they depend on per-frame settings. The same applies to the bit and byte orderings in both directions, the mode-dependent sampling edge, and immunity to configuration changes mid-frame.

// File: rtl/spi_tm_pkg.sv
`timescale 1ns/1ps
package spi_tm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP
    } tm_state_e;

    // Word position carried by serial slot k for a given ordering.
    // Every ordering is its own inverse, so the same map serves both
    // gathering a word into a stream and scattering a stream into a word.
    function automatic int unsigned tm_ser_idx(int unsigned k, bit big, bit lsb,
                                               int unsigned nbytes, int unsigned byte_w);
        int unsigned slot_byte;
        int unsigned slot_bit;
        int unsigned src_byte;
        int unsigned src_bit;
        slot_byte = k / byte_w;
        slot_bit  = k % byte_w;
        src_byte  = big ? (nbytes - 1 - slot_byte) : slot_byte;
        src_bit   = lsb ? slot_bit : (byte_w - 1 - slot_bit);
        return src_byte * byte_w + src_bit;
    endfunction

endpackage

// File: rtl/spi_tm_reorder.sv
`timescale 1ns/1ps
module spi_tm_reorder #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [WORD_W-1:0] din_i,
    input  logic              big_i,
    input  logic              lsb_i,
    output logic [WORD_W-1:0] dout_o
);
    localparam int unsigned NBYTES = WORD_W / BYTE_W;

    for (genvar k = 0; k < WORD_W; k++) begin : g_slot
        localparam int unsigned I_LM = spi_tm_pkg::tm_ser_idx(k, 1'b0, 1'b0, NBYTES, BYTE_W);
        localparam int unsigned I_LL = spi_tm_pkg::tm_ser_idx(k, 1'b0, 1'b1, NBYTES, BYTE_W);
        localparam int unsigned I_BM = spi_tm_pkg::tm_ser_idx(k, 1'b1, 1'b0, NBYTES, BYTE_W);
        localparam int unsigned I_BL = spi_tm_pkg::tm_ser_idx(k, 1'b1, 1'b1, NBYTES, BYTE_W);
        assign dout_o[k] = big_i ? (lsb_i ? din_i[I_BL] : din_i[I_BM])
                                 : (lsb_i ? din_i[I_LL] : din_i[I_LM]);
    end

endmodule

// File: rtl/spi_tm_phase_len.sv
`timescale 1ns/1ps
module spi_tm_phase_len #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             cpol_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    output logic [CNT_W-1:0] lead_len_o,
    output logic [CNT_W-1:0] trail_len_o
);
    // The first half of a bit sits at the non-idle level.
    always_comb begin
        if (cpol_i) begin
            lead_len_o  = low_i;
            trail_len_o = high_i;
        end else begin
            lead_len_o  = high_i;
            trail_len_o = low_i;
        end
    end

endmodule

// File: rtl/spi_timed_master.sv
`timescale 1ns/1ps
module spi_timed_master #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  cfg_setup_i,
    input  logic [CNT_W-1:0]  cfg_hold_i,
    input  logic [CNT_W-1:0]  cfg_idle_i,
    input  logic [CNT_W-1:0]  cfg_low_i,
    input  logic [CNT_W-1:0]  cfg_high_i,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic              cfg_tx_lsb_i,
    input  logic              cfg_rx_lsb_i,
    input  logic              cfg_tx_big_i,
    input  logic              cfg_rx_big_i,
    input  logic              tx_valid_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_ready_o,
    output logic              rx_valid_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    import spi_tm_pkg::*;

    localparam int unsigned        BIT_W    = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] idle;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
        logic             cpol;
        logic             cpha;
        logic             tx_lsb;
        logic             rx_lsb;
        logic             tx_big;
        logic             rx_big;
    } cfg_t;

    typedef struct packed {
        tm_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bit_idx;
        logic              cs_n;
        logic              sck;
        logic              rx_valid;
        logic [WORD_W-1:0] rx_data;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        cfg_t              cfg;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state:    ST_IDLE,
        cnt:      '0,
        bit_idx:  '0,
        cs_n:     1'b1,
        sck:      1'b0,
        rx_valid: 1'b0,
        rx_data:  '0,
        tx_sh:    '0,
        rx_sh:    '0,
        cfg:      '0
    };

    regs_t st_d, st_q;

    cfg_t              cfg_in;
    logic [WORD_W-1:0] tx_stream;
    logic [WORD_W-1:0] rx_word;
    logic [CNT_W-1:0]  lead_len;
    logic [CNT_W-1:0]  trail_len;
    logic              accept;
    logic              lead_edge;
    logic              trail_edge;
    logic              tx_shift;
    logic              rx_shift;
    logic              cpol_lat;

    assign cfg_in = '{
        setup:  cfg_setup_i,
        hold:   cfg_hold_i,
        idle:   cfg_idle_i,
        low:    cfg_low_i,
        high:   cfg_high_i,
        cpol:   cfg_cpol_i,
        cpha:   cfg_cpha_i,
        tx_lsb: cfg_tx_lsb_i,
        rx_lsb: cfg_rx_lsb_i,
        tx_big: cfg_tx_big_i,
        rx_big: cfg_rx_big_i
    };

    // Outgoing word arranged in wire order, slot 0 first.
    spi_tm_reorder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_tx_order (
        .din_i  (tx_data_i),
        .big_i  (cfg_tx_big_i),
        .lsb_i  (cfg_tx_lsb_i),
        .dout_o (tx_stream)
    );

    // Incoming wire-order stream scattered back into word positions.
    spi_tm_reorder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_rx_order (
        .din_i  (st_q.rx_sh),
        .big_i  (st_q.cfg.rx_big),
        .lsb_i  (st_q.cfg.rx_lsb),
        .dout_o (rx_word)
    );

    spi_tm_phase_len #(.CNT_W(CNT_W)) i_phase_len (
        .cpol_i      (st_q.cfg.cpol),
        .low_i       (st_q.cfg.low),
        .high_i      (st_q.cfg.high),
        .lead_len_o  (lead_len),
        .trail_len_o (trail_len)
    );

    assign tx_ready_o = (st_q.state == ST_IDLE) ||
                        ((st_q.state == ST_GAP) && (st_q.cnt == '0));
    assign accept     = tx_valid_i && tx_ready_o;

    always_comb begin
        st_d        = st_q;
        st_d.rx_valid = 1'b0;
        lead_edge   = 1'b0;
        trail_edge  = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                st_d.sck = cfg_cpol_i;
            end
            ST_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.state   = ST_LEAD;
                    st_d.cnt     = lead_len;
                    st_d.sck     = ~st_q.cfg.cpol;
                    st_d.bit_idx = '0;
                    lead_edge    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            ST_LEAD: begin
                if (st_q.cnt == '0) begin
                    st_d.sck   = st_q.cfg.cpol;
                    trail_edge = 1'b1;
                    if (st_q.bit_idx == LAST_BIT) begin
                        st_d.state = ST_HOLD;
                        st_d.cnt   = st_q.cfg.hold;
                    end else begin
                        st_d.state = ST_TRAIL;
                        st_d.cnt   = trail_len;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            ST_TRAIL: begin
                if (st_q.cnt == '0) begin
                    st_d.state   = ST_LEAD;
                    st_d.cnt     = lead_len;
                    st_d.sck     = ~st_q.cfg.cpol;
                    st_d.bit_idx = st_q.bit_idx + 1'b1;
                    lead_edge    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.state    = ST_GAP;
                    st_d.cnt      = st_q.cfg.idle;
                    st_d.cs_n     = 1'b1;
                    st_d.rx_valid = 1'b1;
                    st_d.rx_data  = rx_word;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                if (st_q.cnt == '0) begin
                    st_d.state = ST_IDLE;
                    st_d.sck   = cfg_cpol_i;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                st_d = RESET_VAL;
            end
        endcase

        // Mode 0/2 shift out on the second transition and sample on the first;
        // modes 1/3 swap these, and never shift before the first bit.
        if (st_q.cfg.cpha) begin
            rx_shift = trail_edge;
            tx_shift = lead_edge && (st_q.state == ST_TRAIL);
        end else begin
            rx_shift = lead_edge;
            tx_shift = trail_edge;
        end

        if (tx_shift) begin
            st_d.tx_sh = {1'b0, st_q.tx_sh[WORD_W-1:1]};
        end
        if (rx_shift) begin
            st_d.rx_sh = {miso_i, st_q.rx_sh[WORD_W-1:1]};
        end

        if (accept) begin
            st_d.state = ST_SETUP;
            st_d.cnt   = cfg_setup_i;
            st_d.cs_n  = 1'b0;
            st_d.sck   = cfg_cpol_i;
            st_d.cfg   = cfg_in;
            st_d.tx_sh = tx_stream;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpol_lat   = st_q.cfg.cpol;
    assign cs_n_o     = st_q.cs_n;
    assign sck_o      = st_q.sck;
    assign mosi_o     = st_q.tx_sh[0];
    assign rx_valid_o = st_q.rx_valid;
    assign rx_data_o  = st_q.rx_data;

endmodule

// File: rtl/spi_tm_checker.sv
`timescale 1ns/1ps
module spi_tm_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic cs_n_i,
    input logic sck_i,
    input logic tx_valid_i,
    input logic tx_ready_i,
    input logic rx_valid_i,
    input logic cpol_lat_i
);

    AST_NO_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_i |-> !tx_ready_i); // R1

    AST_ACCEPT_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_i && tx_ready_i) |=> !cs_n_i); // R1

    AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> !rx_valid_i); // R10

    AST_RX_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |-> $rose(cs_n_i)); // R10

    AST_SCK_IDLE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_n_i) |-> (sck_i == cpol_lat_i)); // R6

endmodule

bind spi_timed_master spi_tm_checker i_spi_tm_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_o),
    .sck_i      (sck_o),
    .tx_valid_i (tx_valid_i),
    .tx_ready_i (tx_ready_o),
    .rx_valid_i (rx_valid_o),
    .cpol_lat_i (cpol_lat)
);

// File: tb/test_spi_timed_master.sv
`timescale 1ns/1ps
module test_spi_timed_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_setup, cfg_hold, cfg_idle, cfg_low, cfg_high;
    logic        cfg_cpol, cfg_cpha, cfg_tx_lsb, cfg_rx_lsb, cfg_tx_big, cfg_rx_big;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_ready, rx_valid, cs_n, sck, mosi, miso;
    logic [31:0] rx_data;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     have_prev = 0;
    int     prev_idle = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_timed_master i_spi_timed_master (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_setup_i  (cfg_setup),
        .cfg_hold_i   (cfg_hold),
        .cfg_idle_i   (cfg_idle),
        .cfg_low_i    (cfg_low),
        .cfg_high_i   (cfg_high),
        .cfg_cpol_i   (cfg_cpol),
        .cfg_cpha_i   (cfg_cpha),
        .cfg_tx_lsb_i (cfg_tx_lsb),
        .cfg_rx_lsb_i (cfg_rx_lsb),
        .cfg_tx_big_i (cfg_tx_big),
        .cfg_rx_big_i (cfg_rx_big),
        .tx_valid_i   (tx_valid),
        .tx_data_i    (tx_data),
        .tx_ready_o   (tx_ready),
        .rx_valid_o   (rx_valid),
        .rx_data_o    (rx_data),
        .cs_n_o       (cs_n),
        .sck_o        (sck),
        .mosi_o       (mosi),
        .miso_i       (miso)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Wire order of a word: slot k carries byte (big ? 3-k/8 : k/8),
    // bit (lsb ? k%8 : 7-k%8).
    function automatic logic [31:0] wire_order(input logic [31:0] w, input bit big, input bit lsb);
        logic [31:0] s;
        for (int k = 0; k < 32; k++) begin
            int b   = k / 8;
            int j   = k % 8;
            int byt = big ? 3 - b : b;
            int bt  = lsb ? j : 7 - j;
            s[k] = w[byt*8 + bt];
        end
        return s;
    endfunction

    task automatic frame(input int su, input int ho, input int id, input int lo, input int hi,
                         input bit cpol, input bit cpha, input bit tlsb, input bit rlsb,
                         input bit tbig, input bit rbig, input logic [31:0] tword,
                         input logic [31:0] rword, input bit scramble);
        logic [31:0] exp_stream = wire_order(tword, tbig, tlsb);
        logic [31:0] slv_stream = wire_order(rword, rbig, rlsb);
        logic [31:0] got = '0;
        int     hi_cnt = 0;
        bit     first = 1;
        longint t_fall, t_last;
        bit     sck_prev;
        int     n_edge = 0, n_lead = 0, n_trail = 0, k = 0, phase_err = 0;

        cfg_setup = 8'(su); cfg_hold = 8'(ho); cfg_idle = 8'(id);
        cfg_low = 8'(lo); cfg_high = 8'(hi);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_tx_lsb = tlsb; cfg_rx_lsb = rlsb;
        cfg_tx_big = tbig; cfg_rx_big = rbig;
        tx_data = tword; tx_valid = 1'b1;
        miso = slv_stream[0];

        while (cs_n) begin
            hi_cnt++;
            @(negedge clk);
            if (first && have_prev) check(rx_valid == 1'b0, "R10", "strobe width", rx_valid, 0);
            first = 0;
        end
        if (have_prev) check(hi_cnt == prev_idle + 1, "R5", "release gap", hi_cnt, prev_idle + 1);
        check(tx_ready == 1'b0, "R1", "ready in frame", tx_ready, 0);
        check(sck == cpol, "R6", "sck at select", sck, cpol);
        tx_valid = 1'b0;
        if (scramble) begin
            cfg_setup = 8'($urandom); cfg_hold = 8'($urandom); cfg_idle = 8'($urandom);
            cfg_low = 8'($urandom); cfg_high = 8'($urandom);
            cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_tx_lsb = ~tlsb; cfg_rx_lsb = ~rlsb;
            cfg_tx_big = ~tbig; cfg_rx_big = ~rbig;
            tx_data = ~tword;
        end
        t_fall = cyc; t_last = cyc; sck_prev = sck;

        forever begin
            @(negedge clk);
            if (cs_n) break;
            if (sck != sck_prev) begin
                bit lead = (sck != cpol);
                if (n_edge == 0)
                    check(cyc - t_fall == longint'(su + 1), "R2", "lead-in", cyc - t_fall, su + 1);
                else if (cyc - t_last != longint'((sck_prev ? hi : lo) + 1))
                    phase_err++;
                if (lead) n_lead++; else n_trail++;
                if ((lead && !cpha) || (!lead && cpha)) begin
                    if (k < 32) got[k] = mosi;
                    k++;
                end
                n_edge++;
                t_last = cyc;
                sck_prev = sck;
                if (cpha) begin
                    if (n_lead >= 1 && n_lead <= 32) miso = slv_stream[n_lead - 1];
                end else begin
                    if (n_trail < 32) miso = slv_stream[n_trail];
                end
            end
        end

        check(n_edge == 64, "R3", "edge count", n_edge, 64);
        check(phase_err == 0, "R3", "phase widths", phase_err, 0);
        check(cyc - t_last == longint'(ho + 1), "R4", "tail", cyc - t_last, ho + 1);
        check(sck == cpol, "R6", "sck at release", sck, cpol);
        check(rx_valid == 1'b1, "R10", "strobe at release", rx_valid, 1);
        check(got == exp_stream, "R7 R8", "mosi stream", got, exp_stream);
        check(rx_data == rword, "R7 R9", "received word", rx_data, rword);
        if (scramble)
            check(got == exp_stream && rx_data == rword, "R11", "config latched", rx_data, rword);
        prev_idle = id;
        have_prev = 1;
    endtask

    task automatic pause(input int n);
        repeat (n) @(negedge clk);
        have_prev = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        cfg_setup = '0; cfg_hold = '0; cfg_idle = '0; cfg_low = '0; cfg_high = '0;
        cfg_cpol = 0; cfg_cpha = 0; cfg_tx_lsb = 0; cfg_rx_lsb = 0;
        cfg_tx_big = 0; cfg_rx_big = 0;
        tx_valid = 0; tx_data = '0; miso = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R12", "reset cs_n", cs_n, 1);
        check(tx_ready == 1'b1, "R12", "reset ready", tx_ready, 1);
        check(rx_valid == 1'b0, "R12", "reset strobe", rx_valid, 0);
        check(sck == 1'b0, "R12", "reset sck", sck, 0);

        // Directed corners: minimum counts in each mode, then orderings.
        frame(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0001, 32'h1234_5678, 0);
        frame(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'hA5C3_0F96, 32'hFEDC_BA98, 0);
        frame(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1, 32'h0102_0304, 32'h8001_4002, 0);
        frame(0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 0, 32'hC001_D00D, 32'h0F0F_3C3C, 0);
        frame(2, 3, 1, 9, 0, 0, 0, 1, 1, 1, 1, 32'hDEAD_BEEF, 32'h7654_3210, 0);
        frame(1, 0, 4, 0, 6, 1, 1, 0, 0, 1, 1, 32'h0000_00FF, 32'hFF00_0000, 1);
        pause(3);
        frame(255, 255, 255, 255, 255, 0, 1, 1, 0, 0, 1, 32'h1357_9BDF, 32'h2468_ACE0, 1);
        frame(5, 7, 0, 3, 3, 1, 0, 0, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0000, 0);

        for (int n = 0; n < 28; n++) begin
            int  mx = ($urandom % 4 == 0) ? 1 : 6;
            frame($urandom_range(0, mx), $urandom_range(0, mx), $urandom_range(0, mx),
                  $urandom_range(0, mx), $urandom_range(0, mx),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), $urandom, $urandom, 1'($urandom));
            if (n % 9 == 8) pause(2);
        end

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule